// File: doc/BRIEF.md
# Gated Sync Pulse Distributor

This block takes one asynchronous external sync line and hands it out, gated, to two consumers inside the chip: a signal-monitor path and a clock-divider path. The raw line first passes through a short synchronizer. Each of its rising edges becomes a single-cycle event. That event is copied to each destination whose gate is open.

An 8-bit control register decides which gates are open. It has a global enable bit and one enable bit for each destination. A further bit puts the divider path into a one-shot mode. In that mode the divider path takes only the first qualifying sync event, and the block then clears the divider enable bit by itself. The signal-monitor path always stays continuous. Software writes and reads the register through a plain single-cycle write strobe and a combinational read bus.

Top module: `sync_gate_distributor`

## Requirements
- R1: After a synchronous reset the control register reads 0x00, both outputs are 0, and sync edges produce no output.
- R2: Bit 0 is the global enable. When bit 0 is 0, no sync event reaches either output, whatever the other bits hold.
- R3: `mon_sync_out` pulses for every sync rising edge while bits 7 and 0 are both 1.
- R4: While bits 1 and 0 are 1 and bit 2 is 0, `div_sync_out` pulses for every sync rising edge.
- R5: While bits 0, 1 and 2 are all 1, `div_sync_out` pulses only for the first sync rising edge, and later edges are ignored.
- R6: When that one-shot event is delivered, hardware clears bit 1 in the same clock edge that registers the output. Readback then shows bit 1 as 0, and the monitor path is unaffected.
- R7: Bits 6 to 3 always read 0, and writes to them have no effect on readback or on gating.
- R8: A rising edge of `sync_in` that is first sampled high at clock edge n gives an output pulse that is high for exactly the cycle after edge n+2. A sync input held high gives only one pulse.
- R9: If a register write and the one-shot self-clear fall on the same clock edge, the written value of bit 1 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Value to write into the control register |
| rd_data | output | 8 | Current control register value (combinational) |
| sync_in | input | 1 | Raw external sync line, asynchronous |
| mon_sync_out | output | 1 | Gated sync pulse for the signal-monitor path |
| div_sync_out | output | 1 | Gated sync pulse for the clock-divider path |

## Verification
A gated pulse is due exactly three clock edges after `sync_in` is driven high: two synchronizer stages, then the output register. The bench raises `sync_in` on a falling edge and samples on falling edges. It records both the third falling edge and a six-cycle window, so an early or late pulse fails as surely as a missing one. A register write shows on `rd_data` one edge after the strobe, and readback is sampled on the next falling edge. For the write-versus-self-clear case, the strobe is placed on the same edge that registers the one-shot output.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int CTRL_W   = 8;
    localparam int NUM_DEST = 2;

    // Bits that hold state; reserved bits are dropped on write.
    localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 8'h87;

    typedef enum logic [0:0] {
        DST_MON = 1'b0,
        DST_DIV = 1'b1
    } dest_e;

    typedef struct packed {
        logic       mon_en;    // bit 7
        logic [3:0] rsvd;      // bits 6..3
        logic       div_once;  // bit 2
        logic       div_en;    // bit 1
        logic       master;    // bit 0
    } ctrl_t;

    function automatic ctrl_t ctrl_from_bus(input logic [CTRL_W-1:0] d);
        return ctrl_t'(d & CTRL_WR_MASK);
    endfunction

    function automatic logic dest_open(input ctrl_t c, input int idx);
        logic open_q;
        if (idx == int'(DST_MON)) open_q = c.master & c.mon_en;
        else                      open_q = c.master & c.div_en;
        return open_q;
    endfunction

    function automatic logic oneshot_armed(input ctrl_t c);
        return c.master & c.div_en & c.div_once;
    endfunction

endpackage

// File: rtl/sgd_edge_sync.sv
module sgd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[TOP];
        end
    end

    assign rise = chain[TOP] & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);  // R8

endmodule

// File: rtl/sgd_ctrl_reg.sv
module sgd_ctrl_reg
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              clr_div,
    output ctrl_t             ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= ctrl_from_bus(wr_data);
        end else if (clr_div) begin
            ctrl.div_en <= 1'b0;
        end
    end

    AST_SELF_CLEAR_DIV: assert property (@(posedge clk) disable iff (rst)
        (clr_div && !wr_en) |=> !ctrl.div_en);  // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_div && wr_en) |=> (ctrl.div_en == $past(wr_data[1])));  // R9

    AST_MON_KEPT_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_div && !wr_en) |=> $stable(ctrl.mon_en));  // R6

endmodule

// File: rtl/sgd_gate.sv
module sgd_gate
    import sgd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  ctrl_t               ctrl,
    output logic [NUM_DEST-1:0] pulse_out,
    output logic                oneshot_fire
);

    assign oneshot_fire = rise & oneshot_armed(ctrl);

    for (genvar i = 0; i < NUM_DEST; i++) begin : g_dest
        logic q;

        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= rise & dest_open(ctrl, i);
        end

        assign pulse_out[i] = q;

        AST_PULSE_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
            q |-> $past(ctrl.master));  // R2

        AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            q |=> !q);  // R8
    end

    AST_DIV_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        pulse_out[DST_DIV] |-> $past(ctrl.div_en));  // R4

    AST_MON_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        pulse_out[DST_MON] |-> $past(ctrl.mon_en));  // R3

endmodule

// File: rtl/sync_gate_distributor.sv
module sync_gate_distributor
    import sgd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       sync_in,
    output logic       mon_sync_out,
    output logic       div_sync_out
);

    logic                rise;
    logic                fire;
    ctrl_t               ctrl;
    logic [NUM_DEST-1:0] pulses;

    sgd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .rise     (rise)
    );

    sgd_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr_div (fire),
        .ctrl    (ctrl)
    );

    sgd_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .rise         (rise),
        .ctrl         (ctrl),
        .pulse_out    (pulses),
        .oneshot_fire (fire)
    );

    assign rd_data      = ctrl;
    assign mon_sync_out = pulses[DST_MON];
    assign div_sync_out = pulses[DST_DIV];

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[6:3] == 4'h0));  // R7

    AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (div_sync_out && $past(ctrl.div_once) && !$past(wr_en)) |-> !rd_data[1]);  // R5

endmodule

// File: tb/test_sync_gate_distributor.sv
`timescale 1ns/100ps
module test_sync_gate_distributor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sync_in = 1'b0;
    logic       mon_sync_out;
    logic       div_sync_out;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    sync_gate_distributor i_sync_gate_distributor (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .sync_in      (sync_in),
        .mon_sync_out (mon_sync_out),
        .div_sync_out (div_sync_out)
    );

    // {ctrl value, expected monitor pulse, expected divider pulse}
    localparam logic [9:0] VEC [8] = '{
        {8'h00, 1'b0, 1'b0},
        {8'h80, 1'b0, 1'b0},
        {8'h02, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b0},
        {8'h03, 1'b0, 1'b1},
        {8'h83, 1'b1, 1'b1},
        {8'h01, 1'b0, 1'b0},
        {8'hFB, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // One sync edge; outputs must be high only at the third falling edge.
    task automatic sync_pulse(input string req, input int exp_mon, input int exp_div);
        int n_mon = 0, n_div = 0, at_mon = 0, at_div = 0;
        @(negedge clk);
        sync_in = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (mon_sync_out) begin n_mon++; at_mon = k; end
            if (div_sync_out) begin n_div++; at_div = k; end
            if (k == 3) sync_in = 1'b0;
        end
        chk({req, " mon count"}, n_mon, exp_mon);
        chk({req, " div count"}, n_div, exp_div);
        if (exp_mon != 0) chk({req, " R8 mon timing"}, at_mon, 3);
        if (exp_div != 0) chk({req, " R8 div timing"}, at_div, 3);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int n_mon, n_div;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 rd_data after reset", int'(rd_data), 0);
        chk("R1 mon idle", int'(mon_sync_out), 0);
        chk("R1 div idle", int'(div_sync_out), 0);
        @(negedge clk);
        rst = 1'b0;
        sync_pulse("R1 blocked after reset", 0, 0);

        // Table walk: two edges each, continuous modes (R2 R3 R4 R7)
        foreach (VEC[i]) begin
            reg_write(VEC[i][9:2]);
            chk("R7 readback masked", int'(rd_data), int'(VEC[i][9:2] & 8'h87));
            sync_pulse("R2/R3/R4 table first", int'(VEC[i][1]), int'(VEC[i][0]));
            sync_pulse("R3/R4 table second", int'(VEC[i][1]), int'(VEC[i][0]));
        end

        // R7: reserved-only write
        reg_write(8'h78);
        chk("R7 reserved write reads zero", int'(rd_data), 0);
        sync_pulse("R7 reserved gates nothing", 0, 0);

        // R5 / R6: one-shot divider, monitor continuous
        reg_write(8'h87);
        sync_pulse("R5 first edge", 1, 1);
        chk("R6 div enable self-cleared", int'(rd_data), 8'h85);
        sync_pulse("R5 later edge ignored", 1, 0);
        sync_pulse("R5 still ignored", 1, 0);
        chk("R6 readback stable", int'(rd_data), 8'h85);

        // R2: one-shot bits without master
        reg_write(8'h06);
        sync_pulse("R2 one-shot without master", 0, 0);
        chk("R2 no self-clear without master", int'(rd_data), 8'h06);

        // R8: held-high sync produces one pulse
        reg_write(8'h83);
        n_mon = 0; n_div = 0;
        @(negedge clk);
        sync_in = 1'b1;
        repeat (12) begin
            @(negedge clk);
            n_mon += int'(mon_sync_out);
            n_div += int'(div_sync_out);
        end
        sync_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 held high mon single", n_mon, 1);
        chk("R8 held high div single", n_div, 1);

        // R9: write coincides with the one-shot self-clear edge
        reg_write(8'h07);
        n_div = 0;
        @(negedge clk);
        sync_in = 1'b1;          // sampled at edge n
        @(negedge clk);          // after edge n
        @(negedge clk);          // after edge n+1: fire is live
        wr_en   = 1'b1;
        wr_data = 8'h07;         // strobe lands on edge n+2
        @(negedge clk);
        wr_en   = 1'b0;
        n_div += int'(div_sync_out);
        sync_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 one-shot delivered", n_div, 1);
        chk("R9 write wins over clear", int'(rd_data), 8'h07);
        sync_pulse("R9 still armed after write", 0, 1);
        chk("R6 clear after next edge", int'(rd_data), 8'h05);

        // R1: reset mid-run returns to blocked state
        reg_write(8'h83);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears register", int'(rd_data), 0);
        sync_pulse("R1 blocked after second reset", 0, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule